// File: doc/BRIEF.md
# Line Loss-of-Signal and Clock Monitor

This block watches the receive side of a 2.048 Mbit/s bipolar line interface. It samples the recovered positive and negative rails on the recovered clock and counts how many zero bit times follow each other. Once that run passes a limit, a digital loss-of-signal condition is raised. That condition is merged with a flag from an external analog level detector, and the analog flag is dropped while the local line loopback is engaged. A second detector runs on a free-running reference clock. It raises loss of clock when the recovered clock stops making edges.

The block also drives the receive clock and data toward the terminal side. A shutdown policy parks these outputs at fixed levels when the signal is lost. The parked levels depend on the rail format and on the logic polarity mode. The same outputs are parked while loss of clock is reported. An alarm-test input forces every alarm to its active state and leaves the data path untouched. Both alarms are active-low and start asserted after reset, until real activity clears them.

Top module: `line_alarm_monitor`

## Requirements
- R1: The digital detector raises loss of signal (los_n_o = 0) after more than RUN_LIMIT (default 32) consecutive sampled zero bits; a bit is a zero when both rails are 0. After exactly 32 zeros los_n_o stays 1. While the run continues, the detector stays active.
- R2: A sampled mark (either rail 1) clears the digital detector at that same recovered-clock edge.
- R3: With loopback1_n_i = 1, loss of signal is the OR of the digital detector and analog_los_i. With loopback1_n_i = 0, analog_los_i has no effect.
- R4: los_n_o and loc_n_o are active-low. During and after reset both read 0 until recovered data and clock activity has been seen.
- R5: When shutdown_i = 1 and loss of signal is active, loc_n_o is 0. In single-rail mode, or dual-rail with logic_mode2_i = 0, rclk_o is held at 1 and both data outputs at 0.
- R6: When shutdown_i = 1 and loss of signal is active in dual-rail mode with logic_mode2_i = 1, rclk_o is held at 0 and both data outputs at 1.
- R7: loc_n_o goes to 0 once ABSENT_LIMIT (default 12) reference periods pass with no detected recovered-clock edge. It stays 1 for at least 8 reference periods after the last edge.
- R8: Once raised by clock absence, loc_n_o returns to 1 only after PRESENT_EDGES (default 8) recovered-clock edges are seen, with no absence gap between them.
- R9: While loss of clock is reported (not by alarm test), rclk_o and the data outputs hold the parked levels of R5/R6 and make no transitions.
- R10: With alarm_test_n_i = 0, los_n_o = 0, loc_n_o = 0 and viol_o = 1, and the data outputs still follow the received data. With alarm_test_n_i = 1, viol_o follows viol_i.
- R11: Data path (dual_rail_i selects). In single-rail mode, rdata_pos_o is the OR of the two rails sampled at the last recovered-clock rising edge, rdata_neg_o is 0, and rclk_o equals rclk_i. In dual-rail mode the rails come out separately. With logic_mode2_i = 1 both data rails and rclk_o are inverted. logic_mode2_i is ignored in single-rail mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rclk_i | input | 1 | Recovered receive clock |
| ref_clk_i | input | 1 | Free-running reference clock for the clock-absence timer |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| rx_pos_i | input | 1 | Recovered positive rail, active high |
| rx_neg_i | input | 1 | Recovered negative rail, active high |
| analog_los_i | input | 1 | Analog detector flag, 1 = no signal |
| loopback1_n_i | input | 1 | Local line loopback engaged when 0 |
| shutdown_i | input | 1 | Park receive outputs on loss of signal when 1 |
| alarm_test_n_i | input | 1 | Alarm test when 0 |
| dual_rail_i | input | 1 | 0 = single-rail, 1 = dual-rail outputs |
| logic_mode2_i | input | 1 | Inverted polarity in dual-rail mode when 1 |
| viol_i | input | 1 | Violation flag from the decoder |
| los_n_o | output | 1 | Loss of signal, active-low |
| loc_n_o | output | 1 | Loss of clock, active-low |
| viol_o | output | 1 | Violation flag after alarm-test override |
| rclk_o | output | 1 | Receive clock toward the terminal |
| rdata_pos_o | output | 1 | Unipolar data or positive rail toward the terminal |
| rdata_neg_o | output | 1 | Negative rail toward the terminal (0 in single-rail) |

## Verification
The data outputs and the digital zero-run detector take one recovered-clock rising edge. So the bench drives rails on the falling edge and samples in the high phase after the next rising edge. The alarm merge, the shutdown parking and the alarm test are combinational, so the bench samples them one nanosecond after the inputs change. Loss of clock depends on a synchronizer of two to three reference periods plus the absence count. The bench therefore checks only at safe points: 8 reference periods after the last edge, where the alarm must still be clear, and well past 15 periods, where it must be set. Recovery is checked after 4 and after 14 recovered clocks, one on each side of the 8-edge threshold.

// File: rtl/line_alarm_pkg.sv
// Shared helpers for the line alarm monitor.
// Assumes: rail bits are active high inside the block.
package line_alarm_pkg;

    // Parked receive levels: clock, positive data, negative data.
    typedef struct packed {
        logic clk;
        logic pos;
        logic neg;
    } park_levels_t;

    // Returns the parked output levels for the selected format and polarity.
    function automatic park_levels_t park_levels(input logic dual, input logic mode2);
        park_levels_t p;
        if (dual && mode2) begin
            p.clk = 1'b0;
            p.pos = 1'b1;
            p.neg = 1'b1;
        end else begin
            p.clk = 1'b1;
            p.pos = 1'b0;
            p.neg = 1'b0;
        end
        return p;
    endfunction

endpackage

// File: rtl/zero_run_detector.sv
// Counts consecutive zero bit times on the recovered clock and flags a run
// longer than RUN_LIMIT. Assumes mark_i is sampled on the rising clk edge.
// The count saturates one above the limit, so it never wraps.
module zero_run_detector #(
    parameter int RUN_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_i,
    output logic run_los_o
);
    localparam int CNT_MAX = RUN_LIMIT + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt_q;

    // Zero-run counter: a mark clears it, a zero adds one up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CW'(CNT_MAX);
        end else if (mark_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign run_los_o = (cnt_q == CW'(CNT_MAX));

    // R2
    mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_i |=> !run_los_o);

    // R1
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_los_o && !mark_i) |=> run_los_o);

endmodule

// File: rtl/clock_absence_timer.sv
// Detects a stopped monitored clock using a free-running reference clock.
// A toggle flop on the monitored clock is synchronized into the reference
// domain. Each change of the toggle counts as one edge. Assumes the reference
// clock samples the toggle often enough to see each change.
module clock_absence_timer #(
    parameter int ABSENT_LIMIT  = 12,
    parameter int PRESENT_EDGES = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic ref_clk,
    input  logic mon_clk,
    input  logic rst_n,
    output logic loc_o
);
    localparam int IW = $clog2(ABSENT_LIMIT + 1);
    localparam int EW = $clog2(PRESENT_EDGES + 1);

    logic                 tgl_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 act;
    logic [IW-1:0]        idle_q;
    logic [EW-1:0]        edge_q;
    logic                 loc_q;

    // Toggle flop in the monitored domain; flips on every monitored edge.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= ~tgl_q;
    end

    // Synchronizer chain plus one history stage for change detection.
    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge ref_clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else if (g == 0) sync_q[g] <= tgl_q;
                else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign act = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

    // Idle timer: reference periods since the last seen edge, saturating.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)                          idle_q <= IW'(ABSENT_LIMIT);
        else if (act)                        idle_q <= '0;
        else if (idle_q != IW'(ABSENT_LIMIT)) idle_q <= idle_q + 1'b1;
    end

    // Alarm state: set on a full idle window, cleared after enough edges.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            loc_q  <= 1'b1;
            edge_q <= '0;
        end else if (!loc_q) begin
            edge_q <= '0;
            if (!act && idle_q == IW'(ABSENT_LIMIT - 1)) loc_q <= 1'b1;
        end else if (act) begin
            if (edge_q == EW'(PRESENT_EDGES - 1)) begin
                loc_q  <= 1'b0;
                edge_q <= '0;
            end else begin
                edge_q <= edge_q + 1'b1;
            end
        end else if (idle_q == IW'(ABSENT_LIMIT)) begin
            edge_q <= '0;
        end
    end

    assign loc_o = loc_q;

    // R7
    loc_raise_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!loc_q && !act && idle_q == IW'(ABSENT_LIMIT - 1)) |=> loc_q);

    // R8
    loc_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (loc_q && !act) |=> loc_q);

    // R7
    clear_idle_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !loc_q |-> (idle_q < IW'(ABSENT_LIMIT)));

endmodule

// File: rtl/rx_output_policy.sv
// Selects the terminal-side receive clock and data. It applies the rail
// format, the polarity mode and the parked levels used while frozen.
// Assumes pos_q/neg_q are registered on the recovered clock.
module rx_output_policy
    import line_alarm_pkg::*;
(
    input  logic rclk_i,
    input  logic pos_q,
    input  logic neg_q,
    input  logic dual_i,
    input  logic mode2_i,
    input  logic freeze_i,
    output logic rclk_o,
    output logic pos_o,
    output logic neg_o
);
    park_levels_t park;
    logic         inv;

    assign park = park_levels(dual_i, mode2_i);
    assign inv  = dual_i & mode2_i;

    // Output select: parked levels when frozen, else formatted live data.
    always_comb begin
        if (freeze_i) begin
            rclk_o = park.clk;
            pos_o  = park.pos;
            neg_o  = park.neg;
        end else if (dual_i) begin
            rclk_o = rclk_i ^ inv;
            pos_o  = pos_q ^ inv;
            neg_o  = neg_q ^ inv;
        end else begin
            rclk_o = rclk_i;
            pos_o  = pos_q | neg_q;
            neg_o  = 1'b0;
        end
    end

endmodule

// File: rtl/line_alarm_monitor.sv
// Receive-side loss-of-signal and loss-of-clock monitor. It registers the
// recovered rails, runs the zero-run and clock-absence detectors, and merges
// the alarms with the analog flag, shutdown and alarm-test controls.
// Assumes rclk_i runs during reset so its domain resets too.
module line_alarm_monitor #(
    parameter int RUN_LIMIT     = 32,
    parameter int ABSENT_LIMIT  = 12,
    parameter int PRESENT_EDGES = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic rclk_i,
    input  logic ref_clk_i,
    input  logic rst_n,
    input  logic rx_pos_i,
    input  logic rx_neg_i,
    input  logic analog_los_i,
    input  logic loopback1_n_i,
    input  logic shutdown_i,
    input  logic alarm_test_n_i,
    input  logic dual_rail_i,
    input  logic logic_mode2_i,
    input  logic viol_i,
    output logic los_n_o,
    output logic loc_n_o,
    output logic viol_o,
    output logic rclk_o,
    output logic rdata_pos_o,
    output logic rdata_neg_o
);
    logic pos_q, neg_q;
    logic run_los, timer_loc;
    logic los_raw, loc_raw, freeze;

    // Receive data register on the recovered clock.
    always_ff @(posedge rclk_i) begin
        if (!rst_n) begin
            pos_q <= 1'b0;
            neg_q <= 1'b0;
        end else begin
            pos_q <= rx_pos_i;
            neg_q <= rx_neg_i;
        end
    end

    zero_run_detector #(.RUN_LIMIT(RUN_LIMIT)) u_zero (
        .clk      (rclk_i),
        .rst_n    (rst_n),
        .mark_i   (rx_pos_i | rx_neg_i),
        .run_los_o(run_los)
    );

    clock_absence_timer #(
        .ABSENT_LIMIT (ABSENT_LIMIT),
        .PRESENT_EDGES(PRESENT_EDGES),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_timer (
        .ref_clk(ref_clk_i),
        .mon_clk(rclk_i),
        .rst_n  (rst_n),
        .loc_o  (timer_loc)
    );

    // Alarm merge: analog flag only outside local loopback; shutdown adds LOC.
    always_comb begin
        los_raw = run_los | (analog_los_i & loopback1_n_i);
        loc_raw = timer_loc | (shutdown_i & los_raw);
        freeze  = loc_raw;
        los_n_o = ~(los_raw | ~alarm_test_n_i);
        loc_n_o = ~(loc_raw | ~alarm_test_n_i);
        viol_o  = viol_i | ~alarm_test_n_i;
    end

    rx_output_policy u_out (
        .rclk_i  (rclk_i),
        .pos_q   (pos_q),
        .neg_q   (neg_q),
        .dual_i  (dual_rail_i),
        .mode2_i (logic_mode2_i),
        .freeze_i(freeze),
        .rclk_o  (rclk_o),
        .pos_o   (rdata_pos_o),
        .neg_o   (rdata_neg_o)
    );

    // R5
    sd_loc_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        (shutdown_i && !los_n_o) |-> !loc_n_o);

    // R9
    frozen_clk_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        (!loc_n_o && alarm_test_n_i && !(dual_rail_i && logic_mode2_i)) |-> rclk_o);

    // R10
    alarm_test_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        !alarm_test_n_i |-> (!los_n_o && !loc_n_o && viol_o));

endmodule

// File: tb/tb_line_alarm_monitor.sv
module tb_line_alarm_monitor;
    logic ref_clk = 0, rclk = 0, rclk_en = 1;
    logic rst_n = 0;
    logic rx_pos = 0, rx_neg = 0, analog = 0, lb1_n = 1, sd = 0, alm_n = 1;
    logic dual = 0, mode2 = 0, viol = 0;
    logic los_n, loc_n, viol_o, rclk_o, dpos, dneg;
    int checks = 0, errors = 0;
    bit done = 0;

    // {analog, lb1_n, sd, alm_n, exp los_n, exp loc_n, exp viol}
    localparam logic [6:0] VEC [8] = '{
        7'b0101_110, 7'b1101_010, 7'b1001_110, 7'b1111_000,
        7'b1011_110, 7'b0111_110, 7'b0100_001, 7'b1010_001
    };

    line_alarm_monitor dut (
        .rclk_i(rclk), .ref_clk_i(ref_clk), .rst_n(rst_n),
        .rx_pos_i(rx_pos), .rx_neg_i(rx_neg), .analog_los_i(analog),
        .loopback1_n_i(lb1_n), .shutdown_i(sd), .alarm_test_n_i(alm_n),
        .dual_rail_i(dual), .logic_mode2_i(mode2), .viol_i(viol),
        .los_n_o(los_n), .loc_n_o(loc_n), .viol_o(viol_o),
        .rclk_o(rclk_o), .rdata_pos_o(dpos), .rdata_neg_o(dneg)
    );

    always #5 ref_clk = ~ref_clk;
    always begin
        #20;
        if (rclk_en || rclk) rclk = ~rclk;
    end

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive rails on the falling edge, sample in the high phase after rising.
    task automatic step(input logic p, input logic n);
        @(negedge rclk);
        rx_pos = p;
        rx_neg = n;
        @(posedge rclk);
        #10;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2ms;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (8) @(posedge rclk);
        #10;
        chk("R4 reset alarms", {2'b0, los_n, loc_n}, 4'b0000);
        rst_n = 1;
        repeat (20) step(1, 0);
        chk("R4 cleared after activity", {2'b0, los_n, loc_n}, 4'b0011);

        // Table of static alarm-policy vectors with data flowing.
        foreach (VEC[i]) begin
            {analog, lb1_n, sd, alm_n} = VEC[i][6:3];
            #1;
            chk($sformatf("R3/R5/R10 vector %0d", i), {1'b0, los_n, loc_n, viol_o},
                {1'b0, VEC[i][2:0]});
        end
        {analog, lb1_n, sd, alm_n} = 4'b0101;
        viol = 1; #1;
        chk("R10 viol passthrough", {3'b0, viol_o}, 4'b0001);
        viol = 0;

        // R1 / R2 zero run boundary.
        step(1, 0);
        repeat (32) step(0, 0);
        chk("R1 32 zeros no alarm", {3'b0, los_n}, 4'b0001);
        step(0, 0);
        chk("R1 33 zeros alarm", {3'b0, los_n}, 4'b0000);
        step(0, 0);
        chk("R1 run holds alarm", {3'b0, los_n}, 4'b0000);
        step(0, 1);
        chk("R2 mark clears", {3'b0, los_n}, 4'b0001);

        // R11 data path formats.
        step(0, 1);
        chk("R11 single neg rail", {1'b0, rclk_o, dpos, dneg}, 4'b0110);
        step(0, 0);
        chk("R11 single zero", {1'b0, rclk_o, dpos, dneg}, 4'b0100);
        mode2 = 1;
        step(1, 0);
        chk("R11 single ignores mode2", {1'b0, rclk_o, dpos, dneg}, 4'b0110);
        mode2 = 0; dual = 1;
        step(0, 1);
        chk("R11 dual mode1", {1'b0, rclk_o, dpos, dneg}, 4'b0101);
        mode2 = 1;
        step(1, 0);
        chk("R11 dual mode2 inverted", {1'b0, rclk_o, dpos, dneg}, 4'b0001);

        // R10 data unaffected by alarm test.
        dual = 0; mode2 = 0; alm_n = 0;
        step(0, 1);
        chk("R10 data during test", {2'b0, dpos, dneg}, 4'b0010);
        alm_n = 1;
        step(1, 0);

        // R5 / R6 shutdown parking with loss of signal.
        analog = 1; sd = 1; #1;
        chk("R5 park mode1 high phase", {loc_n, rclk_o, dpos, dneg}, 4'b0100);
        @(negedge rclk); #5;
        chk("R5 park mode1 low phase", {loc_n, rclk_o, dpos, dneg}, 4'b0100);
        dual = 1; mode2 = 1; #1;
        chk("R6 park mode2", {loc_n, rclk_o, dpos, dneg}, 4'b0011);
        @(posedge rclk); #5;
        chk("R6 park mode2 other phase", {loc_n, rclk_o, dpos, dneg}, 4'b0011);
        analog = 0; sd = 0; dual = 0; mode2 = 0;
        step(1, 0);

        // R7 / R9 clock absence.
        @(posedge rclk);
        rclk_en = 0;
        @(negedge rclk);
        repeat (8) @(posedge ref_clk);
        #2;
        chk("R7 no early loc", {3'b0, loc_n}, 4'b0001);
        repeat (20) @(posedge ref_clk);
        #2;
        chk("R7 loc after absence", {3'b0, loc_n}, 4'b0000);
        chk("R9 parked while loc", {1'b0, rclk_o, dpos, dneg}, 4'b0100);

        // R8 recovery.
        rclk_en = 1;
        repeat (4) @(posedge rclk);
        #10;
        chk("R8 loc held before 8 edges", {3'b0, loc_n}, 4'b0000);
        chk("R9 clock parked during recovery", {2'b0, rclk_o, 1'b0}, 4'b0010);
        repeat (10) @(posedge rclk);
        #10;
        chk("R8 loc cleared", {3'b0, loc_n}, 4'b0001);

        finish_run();
    end
endmodule